// File: doc/BRIEF.md
# Reset Delay Sequencer

This block keeps a small processor core in reset until its clock source has had time to settle. It runs from a free-running, low-speed reset clock that is separate from the core clock, so it keeps counting while the core clock is stopped. A power-on event, the release of the external active-low reset pin and a watchdog expiry can each start a hold-off period. While that period runs, the internal reset stays asserted and a busy indicator is high. When the period ends, the core is released.

The length of the hold-off depends on why the reset happened and on the selected oscillator mode. The first release after power-on always uses the long delay. In the two crystal/resonator modes, every later reset also uses the long delay. In the two RC modes, later resets use the short delay. A watchdog expiry goes through the timer only in the crystal modes. In the RC modes it gives a one-cycle reset pulse with no timer. A sticky timeout flag records that a watchdog reset has occurred, and only power-on sets it again. Both delay lengths are parameters counted in reset-clock cycles.

Top module: `rst_delay_seq`

## Requirements
- R1: While `por_n` is low, and afterwards for as long as `mclr_n` stays low, `core_rst` is 1, `to_flag` is 1 and `busy` is 0.
- R2: `core_rst` is 1 in every cycle in which `busy` is 1. It falls in the same cycle in which `busy` falls at the end of a completed delay.
- R3: The first delay after power-on keeps `busy` high for exactly `LONG_CYC` reset-clock cycles, whatever the oscillator mode.
- R4: With `osc_mode` 2'b00 (LP crystal) or 2'b01 (XT crystal), every later delay started by the pin lasts `LONG_CYC` cycles.
- R5: With `osc_mode` 2'b10 (internal RC) or 2'b11 (external RC), every later delay started by the pin lasts `SHORT_CYC` cycles.
- R6: A one-cycle `wdt_to` pulse while the core runs, with `wdt_en` = 1 and a crystal mode selected, raises `core_rst` and `busy` in the next cycle. `busy` then stays high for `LONG_CYC` cycles.
- R7: The same pulse in an RC mode raises `core_rst` for exactly one cycle and leaves `busy` at 0.
- R8: An accepted watchdog expiry clears `to_flag`. It stays 0 through later pin resets and returns to 1 only when `por_n` is asserted.
- R9: When `wdt_en` is 0, `wdt_to` has no effect: `core_rst` stays 0 and `to_flag` keeps its value.
- R10: If `mclr_n` goes low during a delay, `busy` drops while `core_rst` stays 1. When the pin rises again, a full delay restarts from zero, and a power-on delay that was cut short stays long.
- R11: If `mclr_n` goes low while the core runs, `core_rst` rises on the third reset-clock edge after the pin falls. Two edges are taken by pin synchronization and one by the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Free-running low-speed reset clock |
| por_n | input | 1 | Power-on reset, active low, asserts asynchronously |
| mclr_n | input | 1 | External reset pin, active low, asynchronous to `rc_clk` |
| wdt_to | input | 1 | Watchdog expiry pulse, one cycle, synchronous to `rc_clk` |
| osc_mode | input | 2 | Oscillator mode: 00 LP, 01 XT, 10 internal RC, 11 external RC |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| core_rst | output | 1 | Internal reset to the core, active high |
| to_flag | output | 1 | Timeout status: 1 after power-on, 0 after a watchdog reset |
| busy | output | 1 | High while the delay counter runs |

## Verification
A counter that stops early or late changes the number of cycles `busy` stays high, and that difference is visible at the end of a single delay. The bench therefore counts the width of each `busy` window rather than only waiting for release. A wrong "first delay" marker or a wrong mode decode shows up in the first pin reset after power-on, as a short window where a long one is expected or the reverse. A `to_flag` that is wrongly cleared or restored, or a watchdog path taken in the wrong mode, is visible one cycle after the `wdt_to` pulse.

// File: rtl/rst_delay_pkg.sv
package rst_delay_pkg;

  typedef enum logic [1:0] {
    OSC_LP  = 2'b00,
    OSC_XT  = 2'b01,
    OSC_IRC = 2'b10,
    OSC_ERC = 2'b11
  } osc_mode_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'b00,
    ST_COUNT = 2'b01,
    ST_PULSE = 2'b10,
    ST_RUN   = 2'b11
  } seq_state_e;

  function automatic logic is_crystal(input osc_mode_e m);
    return (m == OSC_LP) || (m == OSC_XT);
  endfunction

endpackage

// File: rtl/rdly_bit_sync.sv
module rdly_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rdly_counter.sv
module rdly_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == limit - 1'b1);

  // R3/R4/R5: the count never passes the selected delay length
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!arst_n)
    en |-> (cnt_q < limit));

endmodule

// File: rtl/rst_delay_seq.sv
module rst_delay_seq
  import rst_delay_pkg::*;
#(
  parameter int LONG_CYC  = 18,
  parameter int SHORT_CYC = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic       rc_clk,
  input  logic       por_n,
  input  logic       mclr_n,
  input  logic       wdt_to,
  input  logic [1:0] osc_mode,
  input  logic       wdt_en,
  output logic       core_rst,
  output logic       to_flag,
  output logic       busy
);

  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC);

  logic       rst_sync_n;
  logic       pin_q;
  logic       cnt_done;
  logic [CW-1:0] cnt_limit;
  osc_mode_e  mode_e;
  logic       crystal;
  logic       wdt_hit;

  seq_state_e state_q, state_d;
  logic       first_q, first_d;
  logic       long_q,  long_d;
  logic       to_q,    to_d;

  rdly_bit_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (rc_clk),
    .arst_n (por_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  rdly_bit_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_pin_sync (
    .clk    (rc_clk),
    .arst_n (rst_sync_n),
    .d      (mclr_n),
    .q      (pin_q)
  );

  assign mode_e    = osc_mode_e'(osc_mode);
  assign crystal   = is_crystal(mode_e);
  assign wdt_hit   = wdt_to && wdt_en;
  assign cnt_limit = long_q ? LONG_LIM : SHORT_LIM;

  rdly_counter #(.CW(CW)) u_counter (
    .clk    (rc_clk),
    .arst_n (rst_sync_n),
    .clr    (state_q != ST_COUNT),
    .en     (state_q == ST_COUNT),
    .limit  (cnt_limit),
    .done   (cnt_done)
  );

  always_comb begin
    state_d = state_q;
    first_d = first_q;
    long_d  = long_q;
    to_d    = to_q;
    unique case (state_q)
      ST_HOLD: begin
        if (pin_q) begin
          state_d = ST_COUNT;
          long_d  = first_q || crystal;
        end
      end
      ST_COUNT: begin
        if (!pin_q) begin
          state_d = ST_HOLD;
        end else if (cnt_done) begin
          state_d = ST_RUN;
          first_d = 1'b0;
        end
      end
      ST_PULSE: begin
        state_d = pin_q ? ST_RUN : ST_HOLD;
      end
      ST_RUN: begin
        if (!pin_q) begin
          state_d = ST_HOLD;
        end else if (wdt_hit) begin
          to_d = 1'b0;
          if (crystal) begin
            state_d = ST_COUNT;
            long_d  = 1'b1;
          end else begin
            state_d = ST_PULSE;
          end
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge rc_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_HOLD;
      first_q <= 1'b1;
      long_q  <= 1'b1;
      to_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      long_q  <= long_d;
      to_q    <= to_d;
    end
  end

  assign core_rst = (state_q != ST_RUN);
  assign busy     = (state_q == ST_COUNT);
  assign to_flag  = to_q;

  assert_busy_holds_rst_R2: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    busy |-> core_rst);

  assert_wdt_crystal_delay_R6: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    (state_q == ST_RUN && pin_q && wdt_hit && crystal) |=> (busy && core_rst));

  assert_wdt_rc_pulse_R7: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    (state_q == ST_RUN && pin_q && wdt_hit && !crystal) |=> (core_rst && !busy));

  assert_to_sticky_R8: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    !$rose(to_flag));

  assert_wdt_disabled_R9: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    (state_q == ST_RUN && pin_q && wdt_to && !wdt_en) |=> (!core_rst && $stable(to_flag)));

  assert_pin_abort_R10: assert property (@(posedge rc_clk) disable iff (!rst_sync_n)
    (busy && !pin_q) |=> (!busy && core_rst));

endmodule

// File: tb/rst_delay_seq_bench.sv
`timescale 1ns/1ps
module rst_delay_seq_bench;

  localparam int LONG_CYC  = 18;
  localparam int SHORT_CYC = 3;

  logic       clk = 1'b0;
  logic       por_n, mclr_n, wdt_to, wdt_en;
  logic [1:0] osc_mode;
  logic       core_rst, to_flag, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rst_delay_seq #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_rst_delay_seq (
    .rc_clk   (clk),
    .por_n    (por_n),
    .mclr_n   (mclr_n),
    .wdt_to   (wdt_to),
    .osc_mode (osc_mode),
    .wdt_en   (wdt_en),
    .core_rst (core_rst),
    .to_flag  (to_flag),
    .busy     (busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for busy, measures its width, checks reset is held and then released
  task automatic measure_delay(input string req, input int exp_len);
    int wait_n = 0;
    int len = 0;
    int drop = 0;
    while (!busy && wait_n < 12) begin
      @(negedge clk);
      wait_n++;
    end
    chk(req, "busy started", busy, 1);
    while (busy && len < 60) begin
      if (!core_rst) drop++;
      @(negedge clk);
      len++;
    end
    chk(req, "busy width", len, exp_len);
    chk("R2", "core_rst low while busy", drop, 0);
    chk("R2", "core_rst released with busy", core_rst, 0);
  endtask

  task automatic pin_reset(input string req, input logic [1:0] mode, input int exp_len);
    osc_mode = mode;
    @(negedge clk);
    mclr_n = 1'b0;
    cycles(2);
    chk("R11", "core_rst before third edge", core_rst, 0);
    cycles(1);
    chk("R11", "core_rst on third edge", core_rst, 1);
    cycles(2);
    mclr_n = 1'b1;
    measure_delay(req, exp_len);
  endtask

  task automatic wdt_pulse();
    @(negedge clk);
    wdt_to = 1'b1;
    @(negedge clk);
    wdt_to = 1'b0;
  endtask

  task automatic t_reset_state();
    por_n = 1'b0; mclr_n = 1'b0; wdt_to = 1'b0; wdt_en = 1'b1; osc_mode = 2'b10;
    cycles(3);
    chk("R1", "core_rst in por", core_rst, 1);
    chk("R1", "to_flag in por", to_flag, 1);
    chk("R1", "busy in por", busy, 0);
    por_n = 1'b1;
    cycles(8);
    chk("R1", "core_rst pin low", core_rst, 1);
    chk("R1", "busy pin low", busy, 0);
  endtask

  task automatic t_power_on_abort();
    // R10: cut the first delay short; the restart still uses the long length (R3)
    mclr_n = 1'b1;
    while (!busy) @(negedge clk);
    cycles(4);
    mclr_n = 1'b0;
    cycles(3);
    chk("R10", "busy after abort", busy, 0);
    chk("R10", "core_rst after abort", core_rst, 1);
    cycles(2);
    mclr_n = 1'b1;
    measure_delay("R3", LONG_CYC);
    chk("R3", "to_flag after power-on", to_flag, 1);
  endtask

  task automatic t_mode_delays();
    pin_reset("R5", 2'b10, SHORT_CYC);
    pin_reset("R5", 2'b11, SHORT_CYC);
    pin_reset("R4", 2'b00, LONG_CYC);
    pin_reset("R4", 2'b01, LONG_CYC);
  endtask

  task automatic t_count_abort_rc();
    osc_mode = 2'b10;
    @(negedge clk);
    mclr_n = 1'b0;
    cycles(5);
    mclr_n = 1'b1;
    while (!busy) @(negedge clk);
    cycles(1);
    mclr_n = 1'b0;
    cycles(3);
    chk("R10", "busy dropped", busy, 0);
    chk("R10", "core_rst held", core_rst, 1);
    mclr_n = 1'b1;
    measure_delay("R10", SHORT_CYC);
  endtask

  task automatic t_wdt_disabled();
    wdt_en = 1'b0;
    osc_mode = 2'b01;
    wdt_pulse();
    chk("R9", "core_rst after masked wdt", core_rst, 0);
    cycles(3);
    chk("R9", "core_rst later", core_rst, 0);
    chk("R9", "busy later", busy, 0);
    chk("R9", "to_flag kept", to_flag, 1);
    wdt_en = 1'b1;
  endtask

  task automatic t_wdt_crystal();
    osc_mode = 2'b01;
    wdt_pulse();
    chk("R6", "busy after wdt", busy, 1);
    chk("R6", "core_rst after wdt", core_rst, 1);
    chk("R8", "to_flag cleared", to_flag, 0);
    measure_delay("R6", LONG_CYC);
  endtask

  task automatic t_wdt_rc();
    osc_mode = 2'b11;
    wdt_pulse();
    chk("R7", "core_rst pulse", core_rst, 1);
    chk("R7", "busy stays low", busy, 0);
    cycles(1);
    chk("R7", "core_rst pulse ends", core_rst, 0);
    chk("R8", "to_flag still 0", to_flag, 0);
  endtask

  task automatic t_flag_sticky();
    pin_reset("R5", 2'b10, SHORT_CYC);
    chk("R8", "to_flag after pin reset", to_flag, 0);
    @(negedge clk);
    por_n = 1'b0;
    mclr_n = 1'b0;
    #1;
    chk("R8", "to_flag set by por", to_flag, 1);
    cycles(2);
    por_n = 1'b1;
    cycles(4);
    osc_mode = 2'b11;
    mclr_n = 1'b1;
    measure_delay("R3", LONG_CYC);
  endtask

  logic finished = 1'b0;

  initial begin
    t_reset_state();
    t_power_on_abort();
    t_mode_delays();
    t_count_abort_rc();
    t_wdt_disabled();
    t_wdt_crystal();
    t_wdt_rc();
    t_flag_sticky();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule